// File: doc/BRIEF.md
# Transmit Descriptor Ring with Output Hold Queue

This block is the transmit side of one network interface. Switching logic offers it a packet buffer handle, each tagged with the pool the buffer was drawn from. An accepted packet is either linked straight into a small circular descriptor ring or parked in an output hold queue. Once anything is held, every later packet also goes to the hold queue, so packets leave in the order they arrived. When the hold queue is full, the packet is refused and a drop counter advances.

A media engine inside the block checks the ring once per poll interval. When the ring holds a pending descriptor, the engine presents the oldest handle on the wire-side interface and waits for the serialiser to report it sent. The engine then raises a one-cycle completion event. On that event the host side unlinks the descriptor and hands the buffer handle and its pool tag back on the buffer-return interface. In the same cycle it moves the oldest held packet into the freed descriptor. Buffer storage and serialisation onto the medium are outside the block.

The media engine has three states. In MED_POLL it counts down the poll interval. On the poll tick it moves to MED_SEND if the ring has a pending descriptor, and otherwise reloads the interval and stays in MED_POLL. MED_SEND moves to MED_DONE when wire_done is seen. MED_DONE always returns to MED_POLL and reloads the interval. Each arriving packet gets one admission decision: ADM_RING, ADM_HOLD, ADM_DROP, or ADM_IDLE when nothing arrives.

Top module: `txq_ring`

## Requirements
- R1: After reset, pending is 0, drop_count is 0, and wire_valid and ret_valid are low. pending always reports the number of occupied ring descriptors, from 0 up to RING_DEPTH (4 by default).
- R2: A packet offered while the hold queue is empty and the ring has a free descriptor is linked into the ring, and pending rises by one on the next cycle.
- R3: A packet offered while the hold queue is non-empty goes to the hold queue. A packet offered while the hold queue is empty and the ring is full also goes to the hold queue. In both cases pending does not change.
- R4: A packet offered while the hold queue holds HOLD_DEPTH packets, with no completion in that cycle, is discarded. drop_count rises by one and the handle is never returned.
- R5: The media engine inspects the ring only when its poll interval of POLL_CYC cycles expires. When a descriptor is pending, the engine raises wire_valid with the oldest ring handle and holds both steady until wire_done is sampled high.
- R6: In the cycle after wire_done is sampled, ret_valid is high for exactly one cycle. It carries the sent handle and its pool tag (0 = private pool, 1 = public pool), and that descriptor is freed.
- R7: On each completion the oldest held packet is moved into the freed descriptor, so pending stays the same while the hold queue is non-empty. Handles are returned in exactly the order they were accepted.
- R8: When a packet is offered in the same cycle as a completion, the promotion from the hold queue is done first. The new packet is then placed with the freed space counted: it is not dropped on a full hold queue, and it goes to the ring when the hold queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Packet offered this cycle |
| enq_handle | input | HANDLE_W | Buffer handle of the offered packet |
| enq_pool | input | 1 | Pool tag of the offered packet: 0 private, 1 public |
| wire_valid | output | 1 | Media engine is sending the handle on wire_handle |
| wire_handle | output | HANDLE_W | Handle currently being sent |
| wire_done | input | 1 | Serialiser reports that the current packet has been sent |
| ret_valid | output | 1 | Completion event: buffer is being returned |
| ret_handle | output | HANDLE_W | Handle of the returned buffer |
| ret_pool | output | 1 | Pool tag of the returned buffer |
| pending | output | clog2(RING_DEPTH+1) | Ring descriptors awaiting transmission |
| drop_count | output | DROP_W | Packets dropped on a full hold queue, wrapping |

## Verification
The bench builds the block with a four-entry ring, a four-entry hold queue and a five-cycle poll interval. With these values a handful of packets fills both the ring and the hold queue, so drops, promotions, and a completion that coincides with an arrival on a full hold queue are all reached in a few dozen cycles. The short poll interval also makes it practical to bound the latency from arrival to send, and to drain the full pipeline several times in one run.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam logic POOL_PRIVATE = 1'b0;
    localparam logic POOL_PUBLIC  = 1'b1;

    typedef enum logic [1:0] {
        MED_POLL,
        MED_SEND,
        MED_DONE
    } med_e;

    typedef enum logic [1:0] {
        ADM_IDLE,
        ADM_RING,
        ADM_HOLD,
        ADM_DROP
    } adm_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

    // R4: a push never lands on a full store unless a pop frees a slot
    p_fifo_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(DEPTH)));

    // R6: a pop only happens on a non-empty store
    p_fifo_no_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/txq_media.sv
module txq_media
    import txq_pkg::*;
#(
    parameter int POLL_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_busy,
    input  logic wire_done,
    output logic send,
    output logic cmp
);
    localparam int PCW = (POLL_CYC > 1) ? $clog2(POLL_CYC + 1) : 1;
    localparam logic [PCW-1:0] RELOAD = PCW'(POLL_CYC - 1);

    med_e           state_q;
    med_e           state_d;
    logic [PCW-1:0] poll_q;
    logic           tick;

    assign tick = (state_q == MED_POLL) && (poll_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MED_POLL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MED_POLL: if (tick && ring_busy) state_d = MED_SEND;
            MED_SEND: if (wire_done)         state_d = MED_DONE;
            MED_DONE:                        state_d = MED_POLL;
            default:                         state_d = MED_POLL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_q <= RELOAD;
        end else if (state_q == MED_POLL) begin
            poll_q <= (poll_q == '0) ? RELOAD : poll_q - 1'b1;
        end else begin
            poll_q <= RELOAD;
        end
    end

    always_comb begin
        send = 1'b0;
        cmp  = 1'b0;
        unique case (state_q)
            MED_POLL: ;
            MED_SEND: send = 1'b1;
            MED_DONE: cmp  = 1'b1;
            default:  ;
        endcase
    end

    // R5: sending starts only on an expired poll interval
    p_send_on_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send) |-> $past(poll_q == '0));

    // R5: sending persists until the serialiser acknowledges
    p_send_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !wire_done) |=> send);

    // R6: the completion event lasts one cycle
    p_cmp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp |=> !cmp);
endmodule

// File: rtl/txq_admit.sv
module txq_admit
    import txq_pkg::*;
#(
    parameter int RING_DEPTH = 4,
    parameter int HOLD_DEPTH = 8
) (
    input  logic                            enq_valid,
    input  logic                            cmp,
    input  logic [$clog2(RING_DEPTH+1)-1:0] ring_cnt,
    input  logic [$clog2(HOLD_DEPTH+1)-1:0] hold_cnt,
    output adm_e                            decision,
    output logic                            promote
);
    int ring_occ;
    int hold_occ;

    always_comb begin
        promote  = cmp && (hold_cnt != '0);
        // promotion is applied first, then the new packet is placed
        hold_occ = int'(hold_cnt) - int'(promote);
        ring_occ = int'(ring_cnt) - int'(cmp) + int'(promote);
        decision = ADM_IDLE;
        if (enq_valid) begin
            if (hold_occ != 0) begin
                decision = (hold_occ < HOLD_DEPTH) ? ADM_HOLD : ADM_DROP;
            end else if (ring_occ < RING_DEPTH) begin
                decision = ADM_RING;
            end else begin
                decision = ADM_HOLD;
            end
        end
    end
endmodule

// File: rtl/txq_ring.sv
module txq_ring
    import txq_pkg::*;
#(
    parameter int HANDLE_W   = 8,
    parameter int RING_DEPTH = 4,
    parameter int HOLD_DEPTH = 8,
    parameter int POLL_CYC   = 16,
    parameter int DROP_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enq_valid,
    input  logic [HANDLE_W-1:0]             enq_handle,
    input  logic                            enq_pool,
    output logic                            wire_valid,
    output logic [HANDLE_W-1:0]             wire_handle,
    input  logic                            wire_done,
    output logic                            ret_valid,
    output logic [HANDLE_W-1:0]             ret_handle,
    output logic                            ret_pool,
    output logic [$clog2(RING_DEPTH+1)-1:0] pending,
    output logic [DROP_W-1:0]               drop_count
);
    localparam int EW  = HANDLE_W + 1;
    localparam int RCW = $clog2(RING_DEPTH + 1);
    localparam int HCW = $clog2(HOLD_DEPTH + 1);

    logic [EW-1:0]  new_entry;
    logic [EW-1:0]  ring_head;
    logic [EW-1:0]  hold_head;
    logic [EW-1:0]  ring_din;
    logic [RCW-1:0] ring_cnt;
    logic [HCW-1:0] hold_cnt;
    logic           ring_push;
    logic           hold_push;
    logic           promote;
    logic           cmp;
    logic           send;
    adm_e           decision;

    assign new_entry = {enq_pool, enq_handle};

    txq_admit #(
        .RING_DEPTH(RING_DEPTH),
        .HOLD_DEPTH(HOLD_DEPTH)
    ) admit_i (
        .enq_valid(enq_valid),
        .cmp      (cmp),
        .ring_cnt (ring_cnt),
        .hold_cnt (hold_cnt),
        .decision (decision),
        .promote  (promote)
    );

    assign ring_push = promote || (decision == ADM_RING);
    assign ring_din  = promote ? hold_head : new_entry;
    assign hold_push = (decision == ADM_HOLD);

    txq_fifo #(
        .DEPTH(RING_DEPTH),
        .W    (EW)
    ) ring_i (
        .clk  (clk),
        .rst_n(rst_n),
        .push (ring_push),
        .din  (ring_din),
        .pop  (cmp),
        .head (ring_head),
        .count(ring_cnt)
    );

    txq_fifo #(
        .DEPTH(HOLD_DEPTH),
        .W    (EW)
    ) hold_i (
        .clk  (clk),
        .rst_n(rst_n),
        .push (hold_push),
        .din  (new_entry),
        .pop  (promote),
        .head (hold_head),
        .count(hold_cnt)
    );

    txq_media #(
        .POLL_CYC(POLL_CYC)
    ) media_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ring_busy(ring_cnt != '0),
        .wire_done(wire_done),
        .send     (send),
        .cmp      (cmp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (decision == ADM_DROP) begin
            drop_count <= drop_count + 1'b1;
        end
    end

    assign wire_valid  = send;
    assign wire_handle = ring_head[HANDLE_W-1:0];
    assign ret_valid   = cmp;
    assign ret_handle  = ring_head[HANDLE_W-1:0];
    assign ret_pool    = ring_head[HANDLE_W];
    assign pending     = ring_cnt;

    // R3: anything held means the ring is full, which keeps order
    p_hold_needs_full_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |-> (ring_cnt == RCW'(RING_DEPTH)));

    // R4: the drop counter moves only for an arrival at a full hold queue
    p_drop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
        $past(enq_valid && !cmp && (hold_cnt == HCW'(HOLD_DEPTH))));

    // R5: the handle on the wire is steady while sending
    p_wire_handle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_valid && !wire_done) |=> $stable(wire_handle));

    // R7: a completion with held packets leaves ring occupancy unchanged
    p_promote_keeps_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && (hold_cnt != '0)) |=> (pending == $past(pending)));

    // R8: an arrival with a completion never drops
    p_no_drop_with_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && ret_valid) |=> (drop_count == $past(drop_count)));
endmodule

// File: tb/txq_ring_tb_top.sv
module txq_ring_tb_top;
    localparam int HANDLE_W = 8;
    localparam int RING     = 4;
    localparam int HOLD     = 4;
    localparam int POLL     = 5;
    localparam int DROP_W   = 8;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      enq_valid = 1'b0;
    logic [HANDLE_W-1:0]       enq_handle = '0;
    logic                      enq_pool = 1'b0;
    logic                      wire_valid;
    logic [HANDLE_W-1:0]       wire_handle;
    logic                      wire_done;
    logic                      ret_valid;
    logic [HANDLE_W-1:0]       ret_handle;
    logic                      ret_pool;
    logic [$clog2(RING+1)-1:0] pending;
    logic [DROP_W-1:0]         drop_count;

    logic auto_on   = 1'b0;
    logic auto_done = 1'b0;
    logic man_done  = 1'b0;
    logic finished  = 1'b0;
    int   total = 0;
    int   bad   = 0;
    logic [HANDLE_W:0] exp_q [$];

    assign wire_done = auto_done | man_done;

    always #5 clk = ~clk;

    txq_ring #(
        .HANDLE_W  (HANDLE_W),
        .RING_DEPTH(RING),
        .HOLD_DEPTH(HOLD),
        .POLL_CYC  (POLL),
        .DROP_W    (DROP_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (enq_valid),
        .enq_handle (enq_handle),
        .enq_pool   (enq_pool),
        .wire_valid (wire_valid),
        .wire_handle(wire_handle),
        .wire_done  (wire_done),
        .ret_valid  (ret_valid),
        .ret_handle (ret_handle),
        .ret_pool   (ret_pool),
        .pending    (pending),
        .drop_count (drop_count)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // serialiser model: acknowledge one cycle after seeing a send
    always @(negedge clk) begin
        if (!rst_n || auto_done) auto_done <= 1'b0;
        else if (auto_on && wire_valid) auto_done <= 1'b1;
    end

    // scoreboard monitor (R6, R7)
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R7 actual=%0d expected=none", ret_handle);
            end else begin
                logic [HANDLE_W:0] e;
                e = exp_q.pop_front();
                if ({ret_pool, ret_handle} != e) begin
                    bad++;
                    $display("FAIL R7 actual=%0d/%0d expected=%0d/%0d",
                             ret_handle, ret_pool, e[HANDLE_W-1:0], e[HANDLE_W]);
                end
            end
        end
    end

    // driver: offer one packet, record expectation when it should survive
    task automatic offer(input int h, input logic pool, input logic keep);
        enq_valid  = 1'b1;
        enq_handle = HANDLE_W'(h);
        enq_pool   = pool;
        if (keep) exp_q.push_back({pool, HANDLE_W'(h)});
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    // completion forced by hand, with a packet offered in the completion cycle
    task automatic done_with_offer(input int h, input logic pool);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        check("R6 ret_valid in completion cycle", int'(ret_valid), 1);
        offer(h, pool, 1'b1);
        check("R6 ret_valid single cycle", int'(ret_valid), 0);
    endtask

    task automatic drain();
        auto_on = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pending == 0 && !wire_valid && !ret_valid) break;
        end
        auto_on = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pending", int'(pending), 0);
        check("R1 drop_count", int'(drop_count), 0);
        check("R1 wire_valid", int'(wire_valid), 0);
        check("R1 ret_valid", int'(ret_valid), 0);

        // R2: fill the ring, engine stalled
        offer(8'h10, 1'b0, 1'b1);
        check("R2 pending after first", int'(pending), 1);
        offer(8'h11, 1'b1, 1'b1);
        offer(8'h12, 1'b0, 1'b1);
        offer(8'h13, 1'b1, 1'b1);
        check("R1 pending full", int'(pending), 4);
        repeat (2 * POLL) @(negedge clk);
        check("R5 wire_valid", int'(wire_valid), 1);
        check("R5 wire_handle oldest", int'(wire_handle), 'h10);

        // R3: ring full, hold empty -> hold; hold non-empty -> hold
        for (int i = 0; i < HOLD; i++) offer(8'h20 + i, i[0], 1'b1);
        check("R3 pending unchanged", int'(pending), 4);
        check("R5 wire_handle held", int'(wire_handle), 'h10);

        // R4: hold full -> drops
        offer(8'h30, 1'b0, 1'b0);
        offer(8'h31, 1'b1, 1'b0);
        check("R4 drop_count", int'(drop_count), 2);

        // R8: completion together with an arrival on a full hold queue
        done_with_offer(8'h40, 1'b1);
        check("R8 no drop", int'(drop_count), 2);
        check("R7 pending after promotion", int'(pending), 4);

        drain();
        check("R7 drained pending", int'(pending), 0);
        check("R7 all returned", exp_q.size(), 0);

        // R8: ring full, hold empty, completion with arrival -> ring
        for (int i = 0; i < RING; i++) offer(8'h50 + i, ~i[0], 1'b1);
        repeat (2 * POLL) @(negedge clk);
        check("R5 wire_handle second round", int'(wire_handle), 'h50);
        done_with_offer(8'h54, 1'b0);
        check("R8 arrival went to ring", int'(pending), 4);
        offer(8'h55, 1'b1, 1'b1);
        check("R3 pending with hold", int'(pending), 4);
        drain();
        check("R7 second drain", exp_q.size(), 0);

        // R5: latency from arrival to send bounded by the poll interval
        auto_on = 1'b1;
        repeat (3) @(negedge clk);
        offer(8'h60, 1'b1, 1'b1);
        check("R2 single pending", int'(pending), 1);
        begin
            int lat;
            lat = 0;
            while (!wire_valid && lat < 50) begin
                @(negedge clk);
                lat++;
            end
            check("R5 poll latency bound", int'(lat <= POLL + 2), 1);
        end
        drain();
        check("R6 last returned", exp_q.size(), 0);
        check("R4 drop_count final", int'(drop_count), 2);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule